// File: doc/BRIEF.md
# Dual-Port Pixel Output Formatter

This block takes one stream of digitized RGB pixels, 8 bits per channel, and sends it out on one or two 24-bit output ports. In single-port operation every pixel leaves on port A and port B is disabled. In dual-port operation successive pixels alternate between the ports. The ports can either update in turn (interleaved) or update together once per pixel pair (simultaneous). A half-rate data clock output marks the pixel pairs. Per-channel output-enable signals stand in for high-impedance drivers.

A 4:2:2 option repacks each pixel for luma/chroma sources. Green carries Y. The red field carries chroma that alternates between U and V. The blue field is disabled, so each port uses 16 live lines instead of 24. Pixel parity is counted from the leading edge of the horizontal sync. The four mode inputs are taken in only at that edge, so a line never mixes output formats.

Top module: `pxfmt_top`

## Requirements
- R1: After reset the active mode is dual-port, simultaneous, unswapped and 4:4:4. Both ports read zero, `a_oe` = `b_oe` = 3'b111 and `dclk_out` = 0.
- R2: In single-port mode (`cfg_split`=0) each valid pixel appears on `a_pix` one cycle after it is presented. `b_oe` = 3'b000 and `dclk_out` = 0. Pixel layout is [23:16] red, [15:8] green, [7:0] blue.
- R3: A sync leading edge is a cycle with `hsync`=1 when the previous cycle had `hsync`=0. The mode inputs are latched only in that cycle and also apply to the pixel presented in it. Mode input changes in any other cycle have no effect.
- R4: Pair parity restarts at each sync leading edge, and the pixel presented in the edge cycle is the first of a pair. After reset, before any sync, the first valid pixel is also the first of a pair.
- R5: Dual interleaved mode (`cfg_simul`=0, `cfg_swap`=0): the first pixel of a pair appears on `a_pix` one cycle after it is presented, and the second appears on `b_pix` one cycle after it is presented. Each port holds its value otherwise.
- R6: When `cfg_swap`=1 in dual mode, the port roles are exchanged, so the first pixel after the sync edge goes to port B.
- R7: Dual simultaneous mode: one cycle after the second pixel of a pair, both ports update together. The port of the first pixel (A unless swapped) carries the first pixel and the other port carries the second. A lone first pixel left at a sync edge is dropped.
- R8: In dual mode `dclk_out` is 1 after a first-of-pair pixel and 0 after a second-of-pair pixel. It is cleared by a sync leading edge that carries no pixel, and it stays 0 in single-port mode.
- R9: 4:2:2 mode (`cfg_yc`=1): the green field passes unchanged and the blue field becomes 0. The red field takes the blue input (U) on first-of-pair pixels and the red input (V) on second-of-pair pixels. Bit 0 of each enabled port's output enable is cleared.
- R10: In a cycle without `pix_vld`, neither `a_pix` nor `b_pix` changes.
- R11: Output-enable bits map [2] to red, [1] to green and [0] to blue. `b_oe` equals `a_oe` in dual mode and is 0 in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, active high |
| pix_vld | input | 1 | Pixel valid strobe |
| pix_in | input | 24 | Input pixel {R,G,B} |
| cfg_split | input | 1 | 1 = dual-port demultiplex |
| cfg_simul | input | 1 | 1 = simultaneous pair output, 0 = interleaved |
| cfg_swap | input | 1 | 1 = first pixel of a pair to port B |
| cfg_yc | input | 1 | 1 = 4:2:2 packing |
| a_pix | output | 24 | Port A data |
| b_pix | output | 24 | Port B data |
| a_oe | output | 3 | Port A per-channel drive enable |
| b_oe | output | 3 | Port B per-channel drive enable |
| dclk_out | output | 1 | Half-rate pair clock |

## Verification
Each data result, `dclk_out` value and output-enable change is due at the first rising edge after the cycle that presents its stimulus. The one exception is simultaneous mode, where the first pixel of a pair appears only at the edge after its partner. The bench drives inputs on the falling edge and updates its expected state for that same edge. It then compares every output 1 ns after the following rising edge, so each comparison observes exactly one register update.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

    typedef struct packed {
        logic split;
        logic simul;
        logic swap;
        logic yc;
    } fmt_mode_t;

    localparam fmt_mode_t MODE_RST = '{split: 1'b1, simul: 1'b1, swap: 1'b0, yc: 1'b0};

    typedef enum logic {
        PAIR_LEAD  = 1'b0,
        PAIR_TRAIL = 1'b1
    } pair_st_t;

endpackage

// File: rtl/pxfmt_sync.sv
module pxfmt_sync
    import pxfmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hsync,
    input  fmt_mode_t cfg_in,
    output logic      lead,
    output fmt_mode_t mode_eff,
    output logic      act_split,
    output logic      act_yc
);
    logic      hsync_q;
    fmt_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_q <= 1'b0;
            mode_q  <= MODE_RST;
        end else begin
            hsync_q <= hsync;
            if (lead) begin
                mode_q <= cfg_in;
            end
        end
    end

    always_comb begin
        lead      = hsync & ~hsync_q;
        mode_eff  = lead ? cfg_in : mode_q;
        act_split = mode_q.split;
        act_yc    = mode_q.yc;
    end
endmodule

// File: rtl/pxfmt_pair_fsm.sv
module pxfmt_pair_fsm
    import pxfmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lead,
    input  logic     pix_vld,
    output pair_st_t st_eff
);
    pair_st_t st_q;
    pair_st_t st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PAIR_LEAD;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        st_eff = lead ? PAIR_LEAD : st_q;
        st_nxt = st_eff;
        unique case (st_eff)
            PAIR_LEAD:  if (pix_vld) st_nxt = PAIR_TRAIL;
            PAIR_TRAIL: if (pix_vld) st_nxt = PAIR_LEAD;
        endcase
    end
endmodule

// File: rtl/pxfmt_chroma.sv
module pxfmt_chroma
    import pxfmt_pkg::*;
#(
    parameter int CH_W = 8,
    localparam int PIX_W = 3 * CH_W
) (
    input  logic             yc,
    input  pair_st_t         st,
    input  logic [PIX_W-1:0] pix,
    output logic [PIX_W-1:0] pix_xf
);
    logic [CH_W-1:0] ch_r;
    logic [CH_W-1:0] ch_g;
    logic [CH_W-1:0] ch_b;

    always_comb begin
        ch_r = pix[3*CH_W-1 -: CH_W];
        ch_g = pix[2*CH_W-1 -: CH_W];
        ch_b = pix[CH_W-1 -: CH_W];
        if (yc) begin
            pix_xf = {(st == PAIR_LEAD) ? ch_b : ch_r, ch_g, {CH_W{1'b0}}};
        end else begin
            pix_xf = pix;
        end
    end
endmodule

// File: rtl/pxfmt_route.sv
module pxfmt_route
    import pxfmt_pkg::*;
#(
    parameter int CH_W = 8,
    localparam int PIX_W = 3 * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lead,
    input  logic             pix_vld,
    input  fmt_mode_t        mode,
    input  pair_st_t         st,
    input  logic [PIX_W-1:0] pix_xf,
    input  logic             act_split,
    input  logic             act_yc,
    output logic [PIX_W-1:0] a_pix,
    output logic [PIX_W-1:0] b_pix,
    output logic [2:0]       a_oe,
    output logic [2:0]       b_oe,
    output logic             dclk_out
);
    logic [PIX_W-1:0] hold_q;
    logic             to_b;

    assign to_b = (st == PAIR_TRAIL) ^ mode.swap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_pix    <= '0;
            b_pix    <= '0;
            hold_q   <= '0;
            dclk_out <= 1'b0;
        end else begin
            if (!mode.split || (lead && !pix_vld)) begin
                dclk_out <= 1'b0;
            end else if (pix_vld) begin
                dclk_out <= (st == PAIR_LEAD);
            end
            if (pix_vld) begin
                if (!mode.split) begin
                    a_pix <= pix_xf;
                end else if (!mode.simul) begin
                    if (to_b) b_pix <= pix_xf;
                    else      a_pix <= pix_xf;
                end else if (st == PAIR_LEAD) begin
                    hold_q <= pix_xf;
                end else if (mode.swap) begin
                    b_pix <= hold_q;
                    a_pix <= pix_xf;
                end else begin
                    a_pix <= hold_q;
                    b_pix <= pix_xf;
                end
            end
        end
    end

    always_comb begin
        a_oe = {2'b11, ~act_yc};
        b_oe = act_split ? a_oe : 3'b000;
    end
endmodule

// File: rtl/pxfmt_top.sv
module pxfmt_top
    import pxfmt_pkg::*;
#(
    parameter int CH_W = 8,
    localparam int PIX_W = 3 * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             pix_vld,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             cfg_split,
    input  logic             cfg_simul,
    input  logic             cfg_swap,
    input  logic             cfg_yc,
    output logic [PIX_W-1:0] a_pix,
    output logic [PIX_W-1:0] b_pix,
    output logic [2:0]       a_oe,
    output logic [2:0]       b_oe,
    output logic             dclk_out
);
    fmt_mode_t        cfg_now;
    fmt_mode_t        mode_eff;
    logic             hs_lead;
    logic             act_split;
    logic             act_yc;
    pair_st_t         st_eff;
    logic [PIX_W-1:0] pix_xf;

    assign cfg_now = '{split: cfg_split, simul: cfg_simul, swap: cfg_swap, yc: cfg_yc};

    pxfmt_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .cfg_in    (cfg_now),
        .lead      (hs_lead),
        .mode_eff  (mode_eff),
        .act_split (act_split),
        .act_yc    (act_yc)
    );

    pxfmt_pair_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lead    (hs_lead),
        .pix_vld (pix_vld),
        .st_eff  (st_eff)
    );

    pxfmt_chroma #(.CH_W(CH_W)) u_chroma (
        .yc     (mode_eff.yc),
        .st     (st_eff),
        .pix    (pix_in),
        .pix_xf (pix_xf)
    );

    pxfmt_route #(.CH_W(CH_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead      (hs_lead),
        .pix_vld   (pix_vld),
        .mode      (mode_eff),
        .st        (st_eff),
        .pix_xf    (pix_xf),
        .act_split (act_split),
        .act_yc    (act_yc),
        .a_pix     (a_pix),
        .b_pix     (b_pix),
        .a_oe      (a_oe),
        .b_oe      (b_oe),
        .dclk_out  (dclk_out)
    );
endmodule

// File: rtl/pxfmt_chk.sv
module pxfmt_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_vld,
    input logic             lead,
    input logic [PIX_W-1:0] a_pix,
    input logic [PIX_W-1:0] b_pix,
    input logic [2:0]       a_oe,
    input logic [2:0]       b_oe,
    input logic             dclk_out
);
    // R10: port data only moves on a valid pixel
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_vld) |-> ($stable(a_pix) && $stable(b_pix)));

    // R8: pair clock is quiet whenever port B is disabled (single mode)
    a_r8_single_dclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe == 3'b000) |-> !dclk_out);

    // R3: enables move only after a sync leading edge
    a_r3_mode_at_lead: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lead) |-> ($stable(a_oe) && $stable(b_oe)));

    // R8: in dual mode each mid-line pixel toggles the pair clock
    a_r8_dclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pix_vld) && !$past(lead) && $past(b_oe[1])) |-> (dclk_out != $past(dclk_out)));

    // R11: red and green lanes of port A are always driven
    a_r11_a_rg_on: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe[2:1] == 2'b11);
endmodule

bind pxfmt_top pxfmt_chk #(.PIX_W(PIX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_vld  (pix_vld),
    .lead     (hs_lead),
    .a_pix    (a_pix),
    .b_pix    (b_pix),
    .a_oe     (a_oe),
    .b_oe     (b_oe),
    .dclk_out (dclk_out)
);

// File: tb/test_pxfmt_top.sv
`timescale 1ns/1ps
module test_pxfmt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0;
    logic        pix_vld = 1'b0;
    logic [23:0] pix_in = '0;
    logic        cfg_split = 1'b1, cfg_simul = 1'b1, cfg_swap = 1'b0, cfg_yc = 1'b0;
    logic [23:0] a_pix, b_pix;
    logic [2:0]  a_oe, b_oe;
    logic        dclk_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model state: mode bits {split,simul,swap,yc}
    logic [3:0]  m_mode = 4'b1100;
    logic        m_hq = 1'b0, m_st = 1'b0, e_dclk = 1'b0;
    logic [23:0] m_hold = '0, e_a = '0, e_b = '0;

    always #2 clk = ~clk;

    pxfmt_top i_pxfmt_top (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .pix_vld(pix_vld), .pix_in(pix_in),
        .cfg_split(cfg_split), .cfg_simul(cfg_simul), .cfg_swap(cfg_swap), .cfg_yc(cfg_yc),
        .a_pix(a_pix), .b_pix(b_pix), .a_oe(a_oe), .b_oe(b_oe), .dclk_out(dclk_out)
    );

    function automatic logic [23:0] pack422(logic [23:0] px, logic first);
        return {first ? px[7:0] : px[23:16], px[15:8], 8'h00};
    endfunction

    function automatic string mode_tag(logic [3:0] md);
        if (md[0]) return "R9";
        if (!md[3]) return "R2";
        if (md[2]) return "R7";
        if (md[1]) return "R6";
        return "R5";
    endfunction

    task automatic check(string tag);
        logic [2:0] ea_oe, eb_oe;
        ea_oe = {2'b11, ~m_mode[0]};
        eb_oe = m_mode[3] ? ea_oe : 3'b000;
        n_tests++;
        if (a_pix !== e_a || b_pix !== e_b || dclk_out !== e_dclk ||
            a_oe !== ea_oe || b_oe !== eb_oe) begin
            n_fail++;
            $display("FAIL %s: got a=%h b=%h dclk=%b aoe=%b boe=%b, expected a=%h b=%h dclk=%b aoe=%b boe=%b",
                     tag, a_pix, b_pix, dclk_out, a_oe, b_oe, e_a, e_b, e_dclk, ea_oe, eb_oe);
        end
    endtask

    task automatic step(logic v, logic hs, logic [23:0] px, logic [3:0] cf, string tag);
        logic lead, s;
        logic [3:0] me;
        logic [23:0] xp;
        @(negedge clk);
        pix_vld = v; hsync = hs; pix_in = px;
        {cfg_split, cfg_simul, cfg_swap, cfg_yc} = cf;
        lead = hs && !m_hq;
        me   = lead ? cf : m_mode;
        s    = lead ? 1'b0 : m_st;
        xp   = me[0] ? pack422(px, !s) : px;
        if (!me[3] || (lead && !v)) e_dclk = 1'b0;
        else if (v) e_dclk = !s;
        if (v) begin
            if (!me[3]) e_a = xp;
            else if (!me[2]) begin
                if (s ^ me[1]) e_b = xp; else e_a = xp;
            end else if (!s) m_hold = xp;
            else if (me[1]) begin e_b = m_hold; e_a = xp; end
            else begin e_a = m_hold; e_b = xp; end
        end
        m_st = v ? !s : s;
        m_hq = hs;
        if (lead) m_mode = cf;
        @(posedge clk);
        #1;
        check(tag == "" ? mode_tag(me) : tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int line_len;
        int pos;
        logic [3:0] cf;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1");
        step(1'b0, 1'b0, 24'h0, 4'b1100, "R1");
        // R4: parity before any sync, default simultaneous pair
        step(1'b1, 1'b0, 24'h112233, 4'b1100, "R4");
        step(1'b1, 1'b0, 24'h445566, 4'b1100, "R4");
        // R3: mode inputs ignored away from the leading edge
        step(1'b0, 1'b0, 24'h0, 4'b0000, "R3");
        step(1'b0, 1'b1, 24'h0, 4'b0000, "R3");
        step(1'b1, 1'b1, 24'hA1A2A3, 4'b1100, "R3");
        // R2 single port
        step(1'b1, 1'b0, 24'hB1B2B3, 4'b1100, "R2");
        // R5 interleaved, R8 pair clock, R10 idle hold
        step(1'b0, 1'b0, 24'h0, 4'b1000, "R5");
        step(1'b1, 1'b1, 24'hC1C2C3, 4'b1000, "R5");
        step(1'b1, 1'b0, 24'hD1D2D3, 4'b1000, "R8");
        step(1'b0, 1'b0, 24'hEEEEEE, 4'b1000, "R10");
        // R6 swapped ports
        step(1'b0, 1'b0, 24'h0, 4'b1010, "R6");
        step(1'b1, 1'b1, 24'h0F0E0D, 4'b1010, "R6");
        step(1'b1, 1'b0, 24'h1A1B1C, 4'b1010, "R6");
        // R9 4:2:2 packing in single mode
        step(1'b0, 1'b0, 24'h0, 4'b0001, "R9");
        step(1'b1, 1'b1, 24'h203040, 4'b0001, "R9");
        step(1'b1, 1'b0, 24'h506070, 4'b0001, "R9");
        // R8 sync edge without a pixel clears the pair clock
        step(1'b0, 1'b0, 24'h0, 4'b1000, "R8");
        step(1'b1, 1'b1, 24'h777777, 4'b1000, "R8");
        step(1'b0, 1'b0, 24'h0, 4'b1000, "R8");
        step(1'b0, 1'b1, 24'h0, 4'b1000, "R8");
        // constrained random lines
        for (int ln = 0; ln < 300; ln++) begin
            line_len = 6 + int'($urandom % 20);
            cf = 4'($urandom);
            for (pos = 0; pos < line_len; pos++) begin
                if ($urandom % 8 == 0) cf = 4'($urandom);
                step(($urandom % 4) != 0, pos < 2, 24'($urandom), cf, "");
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule